// File: doc/BRIEF.md
# Memory-Map Region Decoder with Wait-State Accounting

This block sits between a processor-side request port and the memory regions of a handheld-console-style 32-bit address map. Each request carries an address, an access width (byte, halfword or word), a write flag, a fetch strobe and a debug strobe. The top address byte picks the target region. The address is forced into alignment for the access width, and the access goes to the chosen target. Targets are small internal RAMs, a computed read-only firmware image, an 8-bit backup store, or stub inputs that return a value straight away. Reads that hit no backed region go out on an open-bus request and return an externally supplied word.

Every accepted request that is not a debug access adds a wait-state cost to a 64-bit cycle counter. The cost comes from one of four 16-entry tables, indexed by the low nibble of the page. Data and instruction-fetch accesses each have a narrow table (8/16-bit) and a wide table (32-bit). The block is always ready: a request is taken on the edge where `req_valid` is high, and read data appears one cycle later.

Top module: `memmap_bus`

## Requirements
- R1: The target is decoded from `req_addr[31:24]`. Page 0x00 is firmware (read-only) below `FW_BYTES`. Page 0x02 is the external work RAM and 0x03 the internal work RAM. Page 0x04 is the I/O stub and 0x05 the palette RAM. Page 0x06 is the video RAM and 0x07 the object-attribute RAM. Pages 0x08–0x0D are the cartridge stub and pages 0x0E–0x0F the backup store. Every other page is unmapped.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 or 3 = word. A word access clears address bits [1:0], a halfword access clears bit 0, and a byte access keeps the address unchanged. A RAM or firmware read returns the little-endian lane at the aligned address, zero-extended to 32 bits. A RAM write stores the low bytes of `req_wdata` at the aligned address.
- R3: For a data access of byte or halfword width, the cost for page nibble 0x0..0xF is 1,1,3,1,1,1,1,1,5,5,5,5,5,5,5,5.
- R4: For a data access of word width, the cost for page nibble 0x0..0xF is 1,1,6,1,1,2,2,1,8,8,8,8,8,8,8,8.
- R5: With `req_fetch` high, the narrow cost is 1,1,3,1,1,1,1,1,2,2,2,2,2,2,5,5 and the wide cost is 1,1,6,1,1,2,2,1,4,4,4,4,4,4,8,8. The cost table is always indexed by `req_addr[27:24]`, even for pages at 0x10 and above.
- R6: `cycle_count` resets to 0. It adds the cost of each accepted non-debug request on the accepting edge, so the new value is visible in the following cycle. This includes writes to unmapped pages.
- R7: A request with `req_debug` high is a read with the same decode and data as a normal read, whatever `req_write` says. It leaves `cycle_count` unchanged and stores nothing.
- R8: A read from an unmapped page, or from page 0x00 at or above `FW_BYTES`, raises `open_bus_req` in the request cycle, with `open_bus_addr` equal to `req_addr`. Its data is `open_bus_data` rotated right by 8×`req_addr[1:0]` bits and truncated to the access width.
- R9: Writes to firmware, to unmapped pages, to the I/O stub and to the cartridge stub change no stored data and produce no response.
- R10: A backup read uses the unaligned address (low bits index the byte store) and returns the byte replicated: once for byte, ×0x0101 for halfword, ×0x01010101 for word.
- R11: A backup write stores one byte: `req_wdata` shifted right by 8×`addr[1:0]` for word, by 8×`addr[0]` for halfword, and unshifted for byte.
- R12: `rsp_valid` is high exactly one cycle after each read request and low after writes. I/O and cartridge reads return `io_rdata` / `cart_rdata` masked to the access width.
- R13: After reset all RAMs and the backup store read zero. The firmware byte at address a is a[7:0] XOR 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Selects the fetch cost tables |
| req_debug | input | 1 | Debug read: no cost, no store |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address (unaligned allowed) |
| req_wdata | input | 32 | Write value in the low bits |
| io_rdata | input | 32 | I/O stub read value |
| cart_rdata | input | 32 | Cartridge stub read value |
| open_bus_data | input | 32 | Word returned for unmapped reads |
| open_bus_req | output | 1 | Unmapped read in this cycle |
| open_bus_addr | output | 32 | Address of the unmapped read |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cycle_count | output | 64 | Accumulated wait-state cycles |

## Verification
In one cycle a single request both charges the cycle counter and produces read data or a store, and for unmapped or debug traffic the two must separate. Unmapped writes still cost cycles while storing nothing. Debug reads return data while costing nothing. The bench drives mixed random requests, including debug and unmapped writes, and after each one compares the counter with a running total built from its own cost tables. It compares the read data with its own memory model at the same sample, and it follows each ignored write with a read-back of the affected location.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [3:0] {
      RG_FW, RG_EWRAM, RG_IWRAM, RG_IO, RG_PAL,
      RG_VRAM, RG_OAM, RG_CART, RG_BACKUP, RG_OPEN
   } region_e;

   localparam int unsigned RAM_REGIONS = 5;

   function automatic region_e ram_region(input int unsigned slot);
      case (slot)
         0: return RG_EWRAM;
         1: return RG_IWRAM;
         2: return RG_PAL;
         3: return RG_VRAM;
         default: return RG_OAM;
      endcase
   endfunction

   function automatic logic [31:0] align_addr(input logic [31:0] a, input logic [1:0] sz);
      if (sz[1])       return {a[31:2], 2'b00};
      else if (sz[0])  return {a[31:1], 1'b0};
      else             return a;
   endfunction

   function automatic logic [31:0] width_mask(input logic [1:0] sz);
      if (sz[1])       return 32'hFFFF_FFFF;
      else if (sz[0])  return 32'h0000_FFFF;
      else             return 32'h0000_00FF;
   endfunction

   function automatic region_e decode_page(input logic [31:0] a, input logic [31:0] fw_bytes);
      case (a[31:24])
         8'h00: return (a < fw_bytes) ? RG_FW : RG_OPEN;
         8'h02: return RG_EWRAM;
         8'h03: return RG_IWRAM;
         8'h04: return RG_IO;
         8'h05: return RG_PAL;
         8'h06: return RG_VRAM;
         8'h07: return RG_OAM;
         8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: return RG_CART;
         8'h0E, 8'h0F: return RG_BACKUP;
         default: return RG_OPEN;
      endcase
   endfunction

   function automatic logic [31:0] rot_right_bytes(input logic [31:0] d, input logic [1:0] n);
      logic [63:0] dd;
      dd = {d, d} >> {n, 3'b000};
      return dd[31:0];
   endfunction

endpackage

// File: rtl/memmap_cost.sv
module memmap_cost #(
   parameter int unsigned COST_W        = 4,
   parameter bit          SPLIT_FETCH   = 1'b1,
   parameter logic [63:0] TAB_DATA_NAR  = 64'h5555_5555_1111_1311,
   parameter logic [63:0] TAB_DATA_WIDE = 64'h8888_8888_1221_1611,
   parameter logic [63:0] TAB_FET_NAR   = 64'h5522_2222_1111_1311,
   parameter logic [63:0] TAB_FET_WIDE  = 64'h8844_4444_1221_1611
) (
   input  logic [3:0]        page_lo,
   input  logic              wide,
   input  logic              fetch,
   output logic [COST_W-1:0] cost
);
   localparam int unsigned ENTRY_W = 4;

   if (COST_W < ENTRY_W) begin : g_bad_w
      $error("memmap_cost: COST_W must hold a table entry");
   end

   logic [ENTRY_W-1:0] data_cost;
   assign data_cost = wide ? TAB_DATA_WIDE[{page_lo, 2'b00} +: ENTRY_W]
                           : TAB_DATA_NAR[{page_lo, 2'b00} +: ENTRY_W];

   if (SPLIT_FETCH) begin : g_fetch_tab
      logic [ENTRY_W-1:0] fet_cost;
      assign fet_cost = wide ? TAB_FET_WIDE[{page_lo, 2'b00} +: ENTRY_W]
                             : TAB_FET_NAR[{page_lo, 2'b00} +: ENTRY_W];
      assign cost = COST_W'(fetch ? fet_cost : data_cost);
   end else begin : g_data_only
      logic unused_fetch;
      assign unused_fetch = fetch;
      assign cost = COST_W'(data_cost);
   end
endmodule

// File: rtl/memmap_cycle_ctr.sv
module memmap_cycle_ctr #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned COST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_en,
   input  logic [COST_W-1:0] add_val,
   output logic [CNT_W-1:0]  count
);
   if (CNT_W <= COST_W) begin : g_bad_w
      $error("memmap_cycle_ctr: counter narrower than cost");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (add_en) count <= count + CNT_W'(add_val);
   end

   // R6: counter advances by exactly the charged cost
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |=> count == $past(count) + CNT_W'($past(add_val)));
   // R6/R7: counter holds when nothing is charged
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !add_en |=> $stable(count));
endmodule

// File: rtl/memmap_ram.sv
module memmap_ram #(
   parameter int unsigned WORDS = 64,
   parameter int unsigned DW    = 32,
   localparam int unsigned IW    = $clog2(WORDS),
   localparam int unsigned LANES = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_be,
   input  logic [IW-1:0]    idx,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    rd_data
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_depth
      $error("memmap_ram: WORDS must be a power of two >= 2");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("memmap_ram: DW must be a whole number of bytes");
   end

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (wr_en) begin
         for (int b = 0; b < LANES; b++)
            if (wr_be[b]) mem[idx][8*b +: 8] <= wr_data[8*b +: 8];
      end
   end

   assign rd_data = mem[idx];
endmodule

// File: rtl/memmap_bus.sv
module memmap_bus #(
   parameter int unsigned MEM_WORDS = 64,
   parameter int unsigned BK_BYTES  = 64,
   parameter int unsigned FW_BYTES  = 16384,
   parameter int unsigned CNT_W     = 64,
   parameter bit          SPLIT_FETCH = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic        req_fetch,
   input  logic        req_debug,
   input  logic [1:0]  req_size,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   input  logic [31:0] io_rdata,
   input  logic [31:0] cart_rdata,
   input  logic [31:0] open_bus_data,
   output logic        open_bus_req,
   output logic [31:0] open_bus_addr,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   output logic [63:0] cycle_count
);
   import memmap_pkg::*;

   localparam int unsigned COST_W = 4;
   localparam int unsigned MEM_IW = $clog2(MEM_WORDS);
   localparam int unsigned BK_IW  = $clog2(BK_BYTES);
   localparam logic [31:0] FW_LIM = 32'(FW_BYTES);

   if (FW_BYTES == 0 || FW_BYTES > (1 << 24)) begin : g_bad_fw
      $error("memmap_bus: FW_BYTES must lie within one page");
   end
   if (BK_BYTES < 2 || (BK_BYTES & (BK_BYTES - 1)) != 0) begin : g_bad_bk
      $error("memmap_bus: BK_BYTES must be a power of two >= 2");
   end
   if (CNT_W != 64) begin : g_bad_cnt
      $error("memmap_bus: cycle_count port is 64 bits");
   end

   // ---------------- decode and alignment ----------------
   logic [31:0] aligned;
   region_e     region;
   logic        is_read, is_write;

   assign aligned  = align_addr(req_addr, req_size);
   assign region   = decode_page(req_addr, FW_LIM);
   assign is_read  = req_valid && (!req_write || req_debug);
   assign is_write = req_valid && req_write && !req_debug;

   // ---------------- write lane placement ----------------
   logic [3:0]  wr_be;
   logic [31:0] wr_lane;
   always_comb begin
      if (req_size[1])      wr_be = 4'hF;
      else if (req_size[0]) wr_be = 4'b0011 << {aligned[1], 1'b0};
      else                  wr_be = 4'b0001 << aligned[1:0];
   end
   assign wr_lane = req_wdata << {aligned[1:0], 3'b000};

   // ---------------- RAM regions ----------------
   logic [31:0] ram_rd [RAM_REGIONS];
   for (genvar g = 0; g < RAM_REGIONS; g++) begin : g_ram
      logic we;
      assign we = is_write && (region == ram_region(g));
      memmap_ram #(.WORDS(MEM_WORDS), .DW(32)) i_ram (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (we),
         .wr_be   (wr_be),
         .idx     (aligned[MEM_IW+1:2]),
         .wr_data (wr_lane),
         .rd_data (ram_rd[g])
      );
   end

   // ---------------- backup byte store ----------------
   logic [7:0] bk_mem [BK_BYTES];
   logic [7:0] bk_rd, bk_wr;
   logic [1:0] bk_rot;
   logic       bk_we;

   always_comb begin
      if (req_size[1])      bk_rot = req_addr[1:0];
      else if (req_size[0]) bk_rot = {1'b0, req_addr[0]};
      else                  bk_rot = 2'b00;
   end
   assign bk_wr = 8'(req_wdata >> {bk_rot, 3'b000});
   assign bk_we = is_write && (region == RG_BACKUP);
   assign bk_rd = bk_mem[req_addr[BK_IW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BK_BYTES; i++) bk_mem[i] <= '0;
      end else if (bk_we) begin
         bk_mem[req_addr[BK_IW-1:0]] <= bk_wr;
      end
   end

   // ---------------- firmware image ----------------
   function automatic logic [31:0] fw_word(input logic [31:0] a);
      logic [31:0] w;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] lo;
         lo = {a[7:2], 2'(k)};
         w[8*k +: 8] = lo ^ 8'h5A;
      end
      return w;
   endfunction

   // ---------------- read data assembly ----------------
   logic [31:0] raw, rd_value;
   logic        lane_sel;

   always_comb begin
      raw      = '0;
      lane_sel = 1'b0;
      for (int g = 0; g < RAM_REGIONS; g++) begin
         if (region == ram_region(g)) begin
            raw      = ram_rd[g];
            lane_sel = 1'b1;
         end
      end
      case (region)
         RG_FW:     begin raw = fw_word(aligned); lane_sel = 1'b1; end
         RG_IO:     raw = io_rdata;
         RG_CART:   raw = cart_rdata;
         RG_BACKUP: raw = {4{bk_rd}};
         RG_OPEN:   raw = rot_right_bytes(open_bus_data, req_addr[1:0]);
         default:   ;
      endcase
      rd_value = (lane_sel ? (raw >> {aligned[1:0], 3'b000}) : raw) & width_mask(req_size);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= is_read;
         if (is_read) rsp_rdata <= rd_value;
      end
   end

   assign open_bus_req  = is_read && (region == RG_OPEN);
   assign open_bus_addr = req_addr;

   // ---------------- wait-state accounting ----------------
   logic [COST_W-1:0] cost;

   memmap_cost #(.COST_W(COST_W), .SPLIT_FETCH(SPLIT_FETCH)) i_cost (
      .page_lo (req_addr[27:24]),
      .wide    (req_size[1]),
      .fetch   (req_fetch),
      .cost    (cost)
   );

   memmap_cycle_ctr #(.CNT_W(CNT_W), .COST_W(COST_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (req_valid && !req_debug),
      .add_val (cost),
      .count   (cycle_count)
   );

   // ---------------- assertions ----------------
   // R3/R4/R5: every table entry charges between 1 and 8 cycles
   a_r3_cost_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (cost >= 4'd1 && cost <= 4'd8));
   // R7: debug requests never move the counter
   a_r7_debug_free: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_debug) |=> $stable(cycle_count));
   // R12: a read is answered on the next cycle
   a_r12_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (!req_write || req_debug)) |=> rsp_valid);
   // R12: writes produce no response
   a_r12_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_debug) |=> !rsp_valid);
   // R10: word reads of backup return one byte in all lanes
   a_r10_bk_replicate: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && region == RG_BACKUP && req_size[1]) |=>
      (rsp_rdata[31:24] == rsp_rdata[7:0] && rsp_rdata[15:8] == rsp_rdata[7:0]));
   // R8: open-bus requests only accompany reads
   a_r8_open_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus_req |-> (req_valid && (!req_write || req_debug)));
endmodule

// File: tb/test_memmap_bus.sv
module test_memmap_bus;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_debug = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [31:0] io_rdata = '0, cart_rdata = '0, open_bus_data = '0;
   logic        open_bus_req, rsp_valid;
   logic [31:0] open_bus_addr, rsp_rdata;
   logic [63:0] cycle_count;

   always #2 clk = ~clk;   // 250 MHz

   memmap_bus i_memmap_bus (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_fetch(req_fetch), .req_debug(req_debug), .req_size(req_size),
      .req_addr(req_addr), .req_wdata(req_wdata), .io_rdata(io_rdata),
      .cart_rdata(cart_rdata), .open_bus_data(open_bus_data),
      .open_bus_req(open_bus_req), .open_bus_addr(open_bus_addr),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cycle_count(cycle_count)
   );

   int unsigned n_checks = 0, n_errors = 0;
   bit          done = 1'b0;
   logic [63:0] exp_cnt = '0;
   logic [7:0]  ram_m [0:8][0:255];
   logic [7:0]  bk_m  [0:63];

   localparam int FW_SIZE = 16384;
   localparam int OPEN = 9;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic int b_region(input logic [31:0] a);
      case (a[31:24])
         8'h00: return (a < FW_SIZE) ? 0 : OPEN;
         8'h02: return 1;  8'h03: return 2;  8'h04: return 3;
         8'h05: return 4;  8'h06: return 5;  8'h07: return 6;
         8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: return 7;
         8'h0E, 8'h0F: return 8;
         default: return OPEN;
      endcase
   endfunction

   function automatic int b_cost(input logic [3:0] p, input bit wide, input bit fet);
      int dn [16] = '{1,1,3,1,1,1,1,1,5,5,5,5,5,5,5,5};
      int dw [16] = '{1,1,6,1,1,2,2,1,8,8,8,8,8,8,8,8};
      int fn [16] = '{1,1,3,1,1,1,1,1,2,2,2,2,2,2,5,5};
      int fw [16] = '{1,1,6,1,1,2,2,1,4,4,4,4,4,4,8,8};
      if (fet) return wide ? fw[p] : fn[p];
      return wide ? dw[p] : dn[p];
   endfunction

   function automatic int nbytes(input logic [1:0] sz);
      return sz[1] ? 4 : (sz[0] ? 2 : 1);
   endfunction

   function automatic logic [31:0] b_align(input logic [31:0] a, input logic [1:0] sz);
      return a & ~32'(nbytes(sz) - 1);
   endfunction

   function automatic logic [31:0] b_mask(input logic [1:0] sz);
      return sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'hFFFF : 32'hFF);
   endfunction

   function automatic logic [31:0] b_expect(input logic [31:0] a, input logic [1:0] sz,
         input logic [31:0] iov, cav, obv);
      int rg = b_region(a);
      logic [31:0] al = b_align(a, sz);
      logic [31:0] v = '0;
      case (rg)
         0: for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = 8'(al + k) ^ 8'h5A;
         1, 2, 4, 5, 6: for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = ram_m[rg][8'(al + k)];
         3: v = iov & b_mask(sz);
         7: v = cav & b_mask(sz);
         8: v = {4{bk_m[a[5:0]]}} & b_mask(sz);
         default: begin
            for (int k = 0; k < 4; k++) v[8*k +: 8] = obv[8*((k + a[1:0]) % 4) +: 8];
            v = v & b_mask(sz);
         end
      endcase
      return v;
   endfunction

   task automatic do_req(input string dtag, input string ctag, input bit wr, fe, dbg,
         input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
      int rg = b_region(a);
      bit rd = !wr || dbg;
      logic [31:0] iov = $urandom, cav = $urandom, obv = $urandom;
      logic [31:0] ex = b_expect(a, sz, iov, cav, obv);
      int cst = b_cost(a[27:24], sz[1], fe);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_fetch = fe; req_debug = dbg;
      req_size = sz; req_addr = a; req_wdata = wd;
      io_rdata = iov; cart_rdata = cav; open_bus_data = obv;
      #1;
      chk("R8 open_bus_req", 64'(open_bus_req), 64'(rd && rg == OPEN));
      if (rd && rg == OPEN) chk("R8 open_bus_addr", 64'(open_bus_addr), 64'(a));
      @(negedge clk);
      chk("R12 rsp_valid", 64'(rsp_valid), 64'(rd));
      if (rd) chk(dtag, 64'(rsp_rdata), 64'(ex));
      if (!dbg) exp_cnt += 64'(cst);
      chk(ctag, cycle_count, exp_cnt);
      if (wr && !dbg) begin
         logic [31:0] al = b_align(a, sz);
         if (rg == 1 || rg == 2 || rg == 4 || rg == 5 || rg == 6)
            for (int k = 0; k < nbytes(sz); k++) ram_m[rg][8'(al + k)] = wd[8*k +: 8];
         else if (rg == 8) begin
            int rot = sz[1] ? int'(a[1:0]) : (sz[0] ? int'(a[0]) : 0);
            bk_m[a[5:0]] = 8'(wd >> (8 * rot));
         end
      end
      req_valid = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int r = 0; r < 9; r++) for (int i = 0; i < 256; i++) ram_m[r][i] = 8'h00;
      for (int i = 0; i < 64; i++) bk_m[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk("R6 reset count", cycle_count, 64'd0);
      chk("R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 count after reset", cycle_count, 64'd0);

      // R13: RAMs and backup read zero after reset; firmware pattern
      do_req("R13 ewram zero", "R6", 0, 0, 0, 2'd2, 32'h0200_0010, 0);
      do_req("R13 backup zero", "R6", 0, 0, 0, 2'd0, 32'h0E00_0005, 0);
      do_req("R13 fw word", "R6", 0, 0, 0, 2'd2, 32'h0000_0104, 0);
      do_req("R13 fw byte", "R6", 0, 0, 0, 2'd0, 32'h0000_0037, 0);

      // R3 R4 R5: every table entry via the counter
      for (int p = 0; p < 16; p++) begin
         do_req("R1 page sweep", "R3 narrow data cost", 0, 0, 0, 2'd1, {8'(p), 24'h20}, 0);
         do_req("R1 page sweep", "R4 wide data cost",   0, 0, 0, 2'd2, {8'(p), 24'h20}, 0);
         do_req("R1 page sweep", "R5 narrow fetch cost", 0, 1, 0, 2'd0, {8'(p), 24'h21}, 0);
         do_req("R1 page sweep", "R5 wide fetch cost",  0, 1, 0, 2'd2, {8'(p), 24'h24}, 0);
      end
      do_req("R1 high page open", "R5 nibble index", 0, 0, 0, 2'd2, 32'h3A00_0000, 0);

      // R2: alignment of writes and reads
      do_req("R2", "R6", 1, 0, 0, 2'd2, 32'h0300_0007, 32'hA1B2_C3D4);
      do_req("R2 byte lane", "R6", 0, 0, 0, 2'd0, 32'h0300_0006, 0);
      do_req("R2 half align", "R6", 0, 0, 0, 2'd1, 32'h0300_0007, 0);
      do_req("R2", "R6", 1, 0, 0, 2'd1, 32'h0600_0013, 32'hFFFF_5566);
      do_req("R2 half write", "R6", 0, 0, 0, 2'd2, 32'h0600_0010, 0);

      // R8: open bus past firmware size and unmapped page, with rotation
      do_req("R8 fw past size", "R6", 0, 0, 0, 2'd2, 32'h0000_4001, 0);
      do_req("R8 page 01 half", "R6", 0, 0, 0, 2'd1, 32'h0100_0003, 0);

      // R9: ignored writes still cost, then read back
      do_req("R9", "R6 unmapped write cost", 1, 0, 0, 2'd2, 32'h1200_0000, 32'hDEAD_BEEF);
      do_req("R9", "R6", 1, 0, 0, 2'd2, 32'h0000_0040, 32'h1234_5678);
      do_req("R9 fw unchanged", "R6", 0, 0, 0, 2'd2, 32'h0000_0040, 0);
      do_req("R9", "R6", 1, 0, 0, 2'd2, 32'h0400_0000, 32'h1);
      do_req("R12 io stub", "R6", 0, 0, 0, 2'd1, 32'h0400_0000, 0);
      do_req("R12 cart stub", "R6", 0, 0, 0, 2'd0, 32'h0A00_0101, 0);

      // R7: debug read with write flag stores nothing, costs nothing
      do_req("R7 debug", "R7 no cost", 1, 0, 1, 2'd2, 32'h0500_0008, 32'hCAFE_F00D);
      do_req("R7 nothing stored", "R6", 0, 0, 0, 2'd2, 32'h0500_0008, 0);

      // R10 R11: backup rotate and replicate
      do_req("R11", "R6", 1, 0, 0, 2'd2, 32'h0E00_0012, 32'h4433_2211);
      do_req("R10 replicate word", "R6", 0, 0, 0, 2'd2, 32'h0E00_0012, 0);
      do_req("R11", "R6", 1, 0, 0, 2'd1, 32'h0F00_0021, 32'h0000_BBAA);
      do_req("R10 replicate half", "R6", 0, 0, 0, 2'd1, 32'h0F00_0021, 0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [7:0] pages [15] = '{8'h00,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,
                                    8'h08,8'h0C,8'h0E,8'h0F,8'h01,8'h10,8'h3A,8'hFF};
         logic [7:0] pg = pages[$urandom_range(0, 14)];
         logic [31:0] a = {pg, 24'($urandom & 32'h7FFF)};
         logic [1:0] sz = 2'($urandom_range(0, 2));
         bit wr = ($urandom_range(0, 2) == 0);
         bit fe = ($urandom_range(0, 3) == 0);
         bit dbg = ($urandom_range(0, 7) == 0);
         if (pg != 8'h00) a[23:8] = 16'($urandom & 32'h3);
         do_req("R1 random read", "R6 random count", wr, fe, dbg, sz, a, $urandom);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog R6 act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end
endmodule